// File: doc/BRIEF.md
# Pulse-Marked Second and Minute Synchronizer

This block follows the second rhythm of a noisy, slowly varying time-signal level. The level is sampled by a fast system clock. A rising edge becomes a new second only when it lands inside a timing window measured from the previous accepted edge. Edges outside that window are treated as noise. The first edge after a loss of rhythm only serves as a timing reference.

The minute is marked by an unusually long high pulse at second 0. The block watches falling edges and measures how long the level stays high after each accepted second edge. Once that high time passes a threshold that no data pulse reaches, it declares the minute. This happens partway through the marker, not at its end. A running second number restarts at 0 on the marker, so the next accepted second is numbered 1.

All times are clock-cycle counts given as parameters, so a scaled clock can stand in for the 125 MHz system clock. If no second is accepted for a full timeout interval, the block drops lock and searches again.

Top module: `pulse_minute_sync`

## Requirements
- R1: After reset `sec_tick`, `min_tick`, `locked` and `sec_num` are all 0. While searching, the first rising edge of `rx_level` only sets the timing reference and produces no `sec_tick`.
- R2: A rising edge that comes d cycles after the reference is accepted as a new second only when WIN_LO_CYC < d < WIN_HI_CYC (strict on both ends). It raises `sec_tick` for exactly one cycle, on the clock edge SYNC_STAGES cycles after the first edge that samples the high level.
- R3: `locked` rises together with the first accepted `sec_tick`. While locked, a rising edge outside the window produces no tick, leaves `locked` at 1 and does not move the reference.
- R4: While a reference is held but the block is not locked, a rising edge outside the window becomes the new reference.
- R5: When TIMEOUT_CYC cycles pass after the reference with no accepted edge, `locked` clears on the following clock edge. The block then returns to searching, and the next rising edge is only a reference.
- R6: When the high level that began with an accepted second edge lasts more than MARK_CYC cycles, `min_tick` pulses for one cycle exactly MARK_CYC cycles after that `sec_tick`.
- R7: A high pulse of MARK_CYC cycles or fewer produces no `min_tick`, because its falling edge cancels the minute candidate for that second.
- R8: At most one `min_tick` is issued per accepted second, even for a pulse far longer than MARK_CYC. `min_tick` occurs only while locked and never together with `sec_tick`.
- R9: `sec_num` is 0 while not locked and on the lock-acquiring tick. It becomes 0 together with `min_tick` and rises by one on each later `sec_tick`, so the second after the marker reads 1. It saturates at SEC_MAX.
- R10: Short glitches in the middle of a locked second produce no `sec_tick` and no `min_tick`, and do not disturb acceptance of the next on-time edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_level | input | 1 | Asynchronous demodulated time-signal level |
| sec_tick | output | 1 | One-cycle strobe on each accepted second |
| min_tick | output | 1 | One-cycle strobe when the minute marker is recognized |
| locked | output | 1 | High while the second rhythm is tracked |
| sec_num | output | $clog2(SEC_MAX+1) | Second number since the last minute marker |

## Verification
The assertions take the parameter ordering MARK_CYC < WIN_LO_CYC < WIN_HI_CYC < TIMEOUT_CYC for granted. They also assume `rx_level` holds each value for at least one full clock, so every change passes through the synchronizer as a single edge. The stimulus drives the level only on falling clock edges, in whole-cycle pulses, using a small scaled configuration. Event spacing is never below 60 cycles, so edges from one second never overlap the strobes of the previous one. The sweeps cover rise spacings on both sides of each window bound, and marker widths just below, at and above the threshold.

// File: rtl/pms_pkg.sv
package pms_pkg;
  typedef enum logic [1:0] {
    TRK_IDLE   = 2'd0,
    TRK_ARMED  = 2'd1,
    TRK_LOCKED = 2'd2
  } trk_state_e;
endpackage

// File: rtl/pms_edge_sync.sv
module pms_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_in,
  output logic rise,
  output logic fall
);
  // bits [STAGES-1:0] form the synchronizer, bit STAGES holds the previous level
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], sig_in};
  end

  assign rise = chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/pms_second_tracker.sv
module pms_second_tracker
  import pms_pkg::*;
#(
  parameter int WIN_LO_CYC  = 98,
  parameter int WIN_HI_CYC  = 108,
  parameter int TIMEOUT_CYC = 300,
  parameter int CW          = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rise,
  output logic          acc,
  output logic [CW-1:0] cnt,
  output logic          locked,
  output logic          sec_tick
);
  localparam logic [CW-1:0] LO  = CW'(WIN_LO_CYC);
  localparam logic [CW-1:0] HI  = CW'(WIN_HI_CYC);
  localparam logic [CW-1:0] TO  = CW'(TIMEOUT_CYC);
  localparam logic [CW-1:0] ONE = CW'(1);

  trk_state_e st;
  logic       in_win;

  always_comb begin
    in_win = (cnt > LO) && (cnt < HI);
    acc    = rise && (st != TRK_IDLE) && in_win;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= TRK_IDLE;
      cnt      <= '0;
      sec_tick <= 1'b0;
    end else begin
      sec_tick <= acc;
      unique case (st)
        TRK_IDLE: begin
          if (rise) begin
            st  <= TRK_ARMED;
            cnt <= ONE;
          end
        end
        TRK_ARMED: begin
          if (acc) begin
            st  <= TRK_LOCKED;
            cnt <= ONE;
          end else if (rise) begin
            cnt <= ONE;
          end else if (cnt == TO) begin
            st <= TRK_IDLE;
          end else begin
            cnt <= cnt + ONE;
          end
        end
        TRK_LOCKED: begin
          if (acc)              cnt <= ONE;
          else if (cnt == TO)   st  <= TRK_IDLE;
          else                  cnt <= cnt + ONE;
        end
        default: st <= TRK_IDLE;
      endcase
    end
  end

  assign locked = (st == TRK_LOCKED);

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst) cnt <= TO); // R5
  AST_TICK_LOCKED: assert property (@(posedge clk) disable iff (rst) sec_tick |-> locked); // R3
  AST_LOCK_WITH_TICK: assert property (@(posedge clk) disable iff (rst) $rose(locked) |-> sec_tick); // R3
  AST_UNLOCK_TIMEOUT: assert property (@(posedge clk) disable iff (rst) $fell(locked) |-> $past(cnt) == TO); // R5
endmodule

// File: rtl/pms_marker_detect.sv
module pms_marker_detect #(
  parameter int MARK_CYC = 40,
  parameter int CW       = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc,
  input  logic          fall,
  input  logic [CW-1:0] cnt,
  output logic          fire,
  output logic          min_tick
);
  localparam logic [CW-1:0] MK = CW'(MARK_CYC);

  logic cand;

  assign fire = cand && !fall && (cnt == MK);

  always_ff @(posedge clk) begin
    if (rst) begin
      cand     <= 1'b0;
      min_tick <= 1'b0;
    end else begin
      min_tick <= fire;
      if (acc)               cand <= 1'b1;
      else if (fall || fire) cand <= 1'b0;
    end
  end

  AST_MIN_SINGLE: assert property (@(posedge clk) disable iff (rst) min_tick |=> !min_tick); // R8
  AST_FIRE_CLEARS: assert property (@(posedge clk) disable iff (rst) fire |=> !cand); // R8
endmodule

// File: rtl/pms_second_index.sv
module pms_second_index #(
  parameter int SEC_MAX = 60,
  parameter int NW      = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          locked,
  input  logic          acc,
  input  logic          fire,
  output logic [NW-1:0] sec_num
);
  localparam logic [NW-1:0] TOP = NW'(SEC_MAX);

  always_ff @(posedge clk) begin
    if (rst || !locked)     sec_num <= '0;
    else if (fire)          sec_num <= '0;
    else if (acc)           sec_num <= (sec_num == TOP) ? TOP : sec_num + NW'(1);
  end

  AST_NUM_MAX: assert property (@(posedge clk) disable iff (rst) sec_num <= TOP); // R9
endmodule

// File: rtl/pulse_minute_sync.sv
module pulse_minute_sync #(
  parameter int SYNC_STAGES = 2,
  parameter int WIN_LO_CYC  = 122_500_000,
  parameter int WIN_HI_CYC  = 135_000_000,
  parameter int TIMEOUT_CYC = 375_000_000,
  parameter int MARK_CYC    = 50_000_000,
  parameter int SEC_MAX     = 60,
  localparam int CW = $clog2(TIMEOUT_CYC + 1),
  localparam int NW = $clog2(SEC_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_level,
  output logic          sec_tick,
  output logic          min_tick,
  output logic          locked,
  output logic [NW-1:0] sec_num
);
  logic          rise, fall, acc, fire;
  logic [CW-1:0] cnt;

  pms_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .sig_in(rx_level), .rise(rise), .fall(fall)
  );

  pms_second_tracker #(
    .WIN_LO_CYC(WIN_LO_CYC), .WIN_HI_CYC(WIN_HI_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC), .CW(CW)
  ) u_track (
    .clk(clk), .rst(rst), .rise(rise), .acc(acc), .cnt(cnt),
    .locked(locked), .sec_tick(sec_tick)
  );

  pms_marker_detect #(.MARK_CYC(MARK_CYC), .CW(CW)) u_mark (
    .clk(clk), .rst(rst), .acc(acc), .fall(fall), .cnt(cnt),
    .fire(fire), .min_tick(min_tick)
  );

  pms_second_index #(.SEC_MAX(SEC_MAX), .NW(NW)) u_index (
    .clk(clk), .rst(rst), .locked(locked), .acc(acc), .fire(fire),
    .sec_num(sec_num)
  );

  AST_SEC_SINGLE: assert property (@(posedge clk) disable iff (rst) sec_tick |=> !sec_tick); // R2
  AST_MIN_LOCKED: assert property (@(posedge clk) disable iff (rst) min_tick |-> locked); // R8
  AST_MIN_APART: assert property (@(posedge clk) disable iff (rst) !(min_tick && sec_tick)); // R8
  AST_MIN_ZERO: assert property (@(posedge clk) disable iff (rst) min_tick |-> sec_num == '0); // R9
  AST_NUM_IDLE: assert property (@(posedge clk) disable iff (rst) (!locked && $past(!locked)) |-> sec_num == '0); // R9
endmodule

// File: tb/pulse_minute_sync_test.sv
module pulse_minute_sync_test;
  localparam int SYNC = 2;
  localparam int LO   = 98;
  localparam int HI   = 108;
  localparam int TO   = 300;
  localparam int MK   = 40;
  localparam int SMAX = 7;
  localparam int LAT  = SYNC + 1;
  localparam int NW   = $clog2(SMAX + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sig = 1'b0;
  logic          sec_tick, min_tick, locked;
  logic [NW-1:0] sec_num;

  int cyc = 0;
  int n_sec = 0, n_min = 0, last_sec = -1, last_min = -1;
  int checks = 0, errors = 0;
  int exp_num = 0;

  always #10 clk = ~clk;

  pulse_minute_sync #(
    .SYNC_STAGES(SYNC), .WIN_LO_CYC(LO), .WIN_HI_CYC(HI),
    .TIMEOUT_CYC(TO), .MARK_CYC(MK), .SEC_MAX(SMAX)
  ) uut (
    .clk(clk), .rst(rst), .rx_level(sig), .sec_tick(sec_tick),
    .min_tick(min_tick), .locked(locked), .sec_num(sec_num)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst) begin
      if (sec_tick) begin n_sec++; last_sec = cyc; end
      if (min_tick) begin n_min++; last_min = cyc; end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report(input int s0, input int m0, input int r, input int es, input int em, input string tag);
    check(n_sec - s0 == es, {tag, " sec count"}, n_sec - s0, es);
    check(n_min - m0 == em, {tag, " min count"}, n_min - m0, em);
    if (es == 1) check(last_sec == r + LAT, {tag, " sec latency"}, last_sec - r, LAT);
    if (em == 1) check(last_min == r + LAT + MK, {tag, " min latency"}, last_min - r, LAT + MK);
  endtask

  // one rising edge now, high for w cycles, next rise gap cycles later
  task automatic beat(input int w, input int gap, input int es, input int em, input string tag);
    int s0, m0, r;
    s0 = n_sec; m0 = n_min; r = cyc;
    sig = 1'b1;
    repeat (w) @(negedge clk);
    sig = 1'b0;
    repeat (gap - w) @(negedge clk);
    report(s0, m0, r, es, em, tag);
  endtask

  task automatic glitch_beat(input string tag);
    int s0, m0, r;
    s0 = n_sec; m0 = n_min; r = cyc;
    sig = 1'b1; repeat (10) @(negedge clk);
    sig = 1'b0; repeat (40) @(negedge clk);
    sig = 1'b1; repeat (2)  @(negedge clk);
    sig = 1'b0; repeat (18) @(negedge clk);
    sig = 1'b1; repeat (1)  @(negedge clk);
    sig = 1'b0; repeat (29) @(negedge clk);
    report(s0, m0, r, 1, 0, tag);
  endtask

  task automatic quiet(input int n);
    sig = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic relock();
    quiet(TO + 20);
    check(locked == 1'b0, "R5 unlocked after silence", locked, 0);
    beat(10, 100, 0, 0, "R5 reference after timeout");
    beat(10, 100, 1, 0, "R3 relock");
    exp_num = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(sec_tick == 1'b0 && min_tick == 1'b0, "R1 strobes low at reset", sec_tick, 0);
    check(locked == 1'b0, "R1 locked low at reset", locked, 0);
    check(sec_num == '0, "R1 sec_num at reset", int'(sec_num), 0);

    beat(10, 100, 0, 0, "R1 first edge is reference");
    check(locked == 1'b0, "R1 still searching", locked, 0);
    beat(10, 100, 1, 0, "R3 lock acquire");
    check(locked == 1'b1, "R3 locked", locked, 1);
    check(int'(sec_num) == 0, "R9 number on lock tick", int'(sec_num), 0);
    beat(10, 100, 1, 0, "R2 steady second");
    check(int'(sec_num) == 1, "R9 number increments", int'(sec_num), 1);

    // R2 window sweep on both bounds
    for (int d = LO - 3; d <= HI + 3; d++) begin
      int acc_exp;
      acc_exp = (d > LO && d < HI) ? 1 : 0;
      beat(10, d, 1, 0, "R2 lead-in");
      beat(10, 100, acc_exp, 0, "R2 window bound");
      if (acc_exp == 0) begin
        check(locked == 1'b1, "R3 stray edge keeps lock", locked, 1);
        relock();
      end
    end
    exp_num = int'(sec_num);

    // R6 R7 R8 marker width sweep
    begin
      int widths[7] = '{10, 20, MK - 1, MK, MK + 1, 50, 90};
      foreach (widths[i]) begin
        int em;
        em = (widths[i] > MK) ? 1 : 0;
        beat(widths[i], 100, 1, em, em ? "R6 marker width" : "R7 short pulse");
        exp_num = em ? 0 : ((exp_num == SMAX) ? SMAX : exp_num + 1);
        check(int'(sec_num) == exp_num, "R9 number after width", int'(sec_num), exp_num);
      end
    end

    // R9 count up after marker and saturate
    for (int k = 1; k <= SMAX + 2; k++) begin
      beat(10, 100, 1, 0, "R9 counting");
      exp_num = (k > SMAX) ? SMAX : k;
      check(int'(sec_num) == exp_num, "R9 count and saturation", int'(sec_num), exp_num);
    end

    // R10 glitches inside a locked second
    glitch_beat("R10 glitched second");
    check(locked == 1'b1, "R10 lock kept", locked, 1);
    beat(10, 100, 1, 0, "R10 next edge accepted");

    // R4 out-of-window edge re-arms while searching
    quiet(TO + 20);
    check(locked == 1'b0, "R5 unlocked", locked, 0);
    check(sec_num == '0, "R9 number cleared while searching", int'(sec_num), 0);
    beat(10, 60, 0, 0, "R4 reference");
    beat(10, 100, 0, 0, "R4 early edge re-references");
    beat(10, 100, 1, 0, "R4 accepted from new reference");

    // R5 exact timeout edge
    begin
      int r;
      r = cyc;
      beat(10, 10, 1, 0, "R5 last accepted");
      while (cyc < r + LAT + TO - 1) @(negedge clk);
      check(locked == 1'b1, "R5 locked just before timeout", locked, 1);
      @(negedge clk);
      check(locked == 1'b0, "R5 unlocked at timeout", locked, 0);
    end
    quiet(50);

    // R8 long pulse on the reference edge gives no minute; on the lock edge it does
    beat(50, 100, 0, 0, "R8 no minute while searching");
    beat(50, 100, 1, 1, "R8 minute on lock edge");
    check(int'(sec_num) == 0, "R9 cleared by minute", int'(sec_num), 0);
    beat(10, 100, 1, 0, "R9 second after marker");
    check(int'(sec_num) == 1, "R9 second after marker is 1", int'(sec_num), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule